// File: doc/BRIEF.md
# External Event Counter Channel

This block is one timer channel that counts pulses on an asynchronous input pin instead of clock cycles. Software loads a period into a reload register, selects which pin transitions count (rising, falling or both), and writes a start trigger. The start trigger copies the reload value into a down-counter. The channel then waits for qualifying edges and takes one count off for each. When an edge finds the counter at zero, the counter is refilled from the reload register and a one-cycle interrupt pulse is raised. A reload value of N therefore gives one interrupt every N+1 qualifying edges.

A stop trigger freezes the counter where it stands. The reload register can be rewritten at any time, and the new value takes effect at the next refill. The mode register is locked while the channel runs. A unit-level enable acts as a soft reset: while it is low, every channel register returns to its default and register writes are ignored. The pin passes through a two-flop synchronizer before edge detection.

Top module: `evt_count_chan`

## Requirements
- R1: After reset, and at every clock edge where `unit_en` is low, the channel returns to its defaults. The defaults are: counter FFFFH, reload 0000H, mode word 0, channel inactive and interrupt low. Writes presented while `unit_en` is low have no effect.
- R2: A write of 1 to bit 0 of register 0 (the start trigger) sets the active flag and copies the reload value into the counter at that clock edge. The counter then stays unchanged until a qualifying pin edge arrives.
- R3: While the channel is active, each qualifying edge that finds the counter non-zero decrements it by exactly one. Mode bits [1:0] select the qualifying edges: 00 = rising, 01 = falling, 10 or 11 = both.
- R4: While the channel is active, a qualifying edge that finds the counter at zero loads the reload value into the counter and drives `irq_o` high for exactly one cycle. No other event raises `irq_o`.
- R5: A write of 1 to bit 1 of register 0 (the stop trigger) clears the active flag. The counter then holds its value and ignores pin edges.
- R6: If the start and stop bits are written as 1 in the same write, stop wins and the channel ends inactive.
- R7: Register 0 always reads as zero. Both trigger bits act only in the cycle they are written.
- R8: Register 1 (reload) accepts writes at any time, including while the channel counts. Such a write leaves the running counter untouched, and the next refill uses the new value.
- R9: Register 2 (mode) holds the edge select in bits [1:0] and an output-enable bit in bit 2. It ignores writes while the channel is active. When read, it also reports the active flag in bit 8. Register 3 reads the counter.
- R10: A pin transition first affects the counter at the third rising clock edge after the pin changes. That edge covers two synchronizer flops and one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Unit clock enable; low resets the channel and blocks writes |
| evt_pin | input | 1 | Asynchronous event input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address (0 trigger, 1 reload, 2 mode, 3 none) |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address (0 trigger, 1 reload, 2 mode/status, 3 counter) |
| rd_data | output | 16 | Combinational read data |
| active_o | output | 1 | Channel-active flag |
| irq_o | output | 1 | One-cycle interrupt pulse on refill |

## Verification
The bench sweeps every edge-select encoding against small reload values, including zero. It predicts the counter after each pin toggle and the total number of interrupts. A design that refills on the wrong edge, or counts the reload value as N rather than N+1 edges, shows up as a count or interrupt mismatch. The bench also targets four other faults: a combined start/stop write that leaves the channel running, a reload write that disturbs the live counter, a mode write that gets through while running, and a counter that drifts after stop. A soft disable that does not clear the reload register, or that lets a write through, shows up as a wrong readback once the unit is enabled again.

// File: rtl/evt_count_pkg.sv
package evt_count_pkg;

  localparam logic [1:0] ADDR_TRIG   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;
  localparam logic [1:0] ADDR_COUNT  = 2'd3;

  localparam int TRIG_START_BIT  = 0;
  localparam int TRIG_STOP_BIT   = 1;
  localparam int MODE_W          = 3;
  localparam int STAT_ACTIVE_BIT = 8;

  localparam logic [1:0] EDGE_RISE = 2'b00;
  localparam logic [1:0] EDGE_FALL = 2'b01;

  typedef struct packed {
    logic       out_en;
    logic [1:0] edge_sel;
  } mode_t;

  // Qualifying-edge decision from the current and previous synchronized level.
  function automatic logic edge_match(input logic [1:0] sel,
                                      input logic cur, input logic prev);
    case (sel)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      default:   return cur ^ prev;
    endcase
  endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       hit
);
  import evt_count_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[LAST];
    end
  end

  assign hit = edge_match(edge_sel, sync_q[LAST], prev_q);

endmodule

// File: rtl/evt_regs.sv
module evt_regs #(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     unit_en,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [CNT_W-1:0]         wr_data,
  output logic                     start_req,
  output logic                     stop_req,
  output logic                     mode_wr,
  output logic                     active,
  output logic [CNT_W-1:0]         reload,
  output evt_count_pkg::mode_t     mode
);
  import evt_count_pkg::*;

  logic  wr_ok;
  logic  trig_wr;
  logic  reload_wr;
  mode_t mode_d;

  assign wr_ok     = unit_en & wr_en;
  assign trig_wr   = wr_ok & (wr_addr == ADDR_TRIG);
  assign reload_wr = wr_ok & (wr_addr == ADDR_RELOAD);
  assign mode_wr   = wr_ok & (wr_addr == ADDR_MODE) & ~active;
  assign stop_req  = trig_wr & wr_data[TRIG_STOP_BIT];
  assign start_req = trig_wr & wr_data[TRIG_START_BIT] & ~wr_data[TRIG_STOP_BIT];
  assign mode_d    = mode_t'(wr_data[MODE_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      reload <= '0;
      mode   <= '0;
    end else if (!unit_en) begin
      active <= 1'b0;
      reload <= '0;
      mode   <= '0;
    end else begin
      if (stop_req)       active <= 1'b0;
      else if (start_req) active <= 1'b1;
      if (reload_wr)      reload <= wr_data;
      if (mode_wr)        mode   <= mode_d;
    end
  end

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_en,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             active,
  input  logic             hit,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             zero_hit
);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  logic count_en;

  assign count_en = active & hit & ~start_req & ~stop_req;
  assign zero_hit = count_en & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '1;
      irq <= 1'b0;
    end else if (!unit_en) begin
      cnt <= '1;
      irq <= 1'b0;
    end else begin
      irq <= zero_hit;
      if (stop_req)       cnt <= cnt;
      else if (start_req) cnt <= reload;
      else if (count_en)  cnt <= step(cnt, reload);
    end
  end

endmodule

// File: rtl/evt_count_chan.sv
module evt_count_chan #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_en,
  input  logic             evt_pin,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             active_o,
  output logic             irq_o
);
  import evt_count_pkg::*;

  logic             start_req;
  logic             stop_req;
  logic             mode_wr;
  logic             active_q;
  logic [CNT_W-1:0] reload_q;
  mode_t            mode_q;
  logic [MODE_W-1:0] mode_bits;
  logic             evt_hit;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             zero_hit;
  logic [CNT_W-1:0] stat_word;

  evt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_req(start_req), .stop_req(stop_req), .mode_wr(mode_wr),
    .active(active_q), .reload(reload_q), .mode(mode_q)
  );

  evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(evt_pin),
    .edge_sel(mode_q.edge_sel), .hit(evt_hit)
  );

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
    .start_req(start_req), .stop_req(stop_req), .active(active_q),
    .hit(evt_hit), .reload(reload_q),
    .cnt(cnt_q), .irq(irq_q), .zero_hit(zero_hit)
  );

  assign mode_bits = mode_q;

  always_comb begin
    stat_word                  = '0;
    stat_word[MODE_W-1:0]      = mode_bits;
    stat_word[STAT_ACTIVE_BIT] = active_q;
  end

  always_comb begin
    case (rd_addr)
      ADDR_RELOAD: rd_data = reload_q;
      ADDR_MODE:   rd_data = stat_word;
      ADDR_COUNT:  rd_data = cnt_q;
      default:     rd_data = '0;
    endcase
  end

  assign active_o = active_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/evt_count_chan_chk.sv
module evt_count_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             unit_en,
  input logic             start_req,
  input logic             stop_req,
  input logic             active_q,
  input logic             evt_hit,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [2:0]       mode_bits,
  input logic             irq_q
);

  a_r1_unit_off: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> (cnt_q == '1) && !active_q && (reload_q == '0) && !irq_q && (mode_bits == '0));

  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> active_q && (cnt_q == $past(reload_q)));

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && active_q && evt_hit && !start_req && !stop_req && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r4_zero_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && active_q && evt_hit && !start_req && !stop_req && cnt_q == '0)
      |=> irq_q && (cnt_q == $past(reload_q)));

  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(evt_hit) && $past(active_q) && ($past(cnt_q) == '0));

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && !active_q && !start_req) |=> $stable(cnt_q));

  a_r6_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !active_q);

  a_r9_mode_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && active_q) |=> $stable(mode_bits));

endmodule

bind evt_count_chan evt_count_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
  .start_req(start_req), .stop_req(stop_req), .active_q(active_q),
  .evt_hit(evt_hit), .cnt_q(cnt_q), .reload_q(reload_q),
  .mode_bits(mode_bits), .irq_q(irq_q)
);

// File: tb/evt_count_chan_tb.sv
module evt_count_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unit_en = 1'b1;
  logic        evt_pin = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        active_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int irq_seen = 0;

  always #4 clk = ~clk;

  evt_count_chan u_dut (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .evt_pin(evt_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .active_o(active_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (irq_o) irq_seen++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic toggle();
    @(negedge clk);
    evt_pin = ~evt_pin;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit qualifies(input int sel, input logic lvl);
    if (sel == 0) return lvl == 1'b1;
    if (sel == 1) return lvl == 1'b0;
    return 1'b1;
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int exp_cnt;
    int exp_irq;
    int base;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset defaults
    rd(2'd3, v); check("R1 counter reset", v, 16'hFFFF);
    rd(2'd1, v); check("R1 reload reset", v, 16'h0000);
    rd(2'd2, v); check("R1 mode reset", v, 16'h0000);
    check("R1 active reset", active_o, 1'b0);
    check("R1 irq reset", irq_o, 1'b0);

    // R5 counter ignores edges while never started
    toggle(); toggle();
    rd(2'd3, v); check("R5 idle ignores edges", v, 16'hFFFF);

    // R3/R4/R2 sweep over edge modes and reload values
    for (int sel = 0; sel < 3; sel++) begin
      for (int r = 0; r < 5; r++) begin
        wr(2'd0, 16'h0002);
        wr(2'd2, 16'(sel));
        wr(2'd1, 16'(r));
        wr(2'd0, 16'h0001);
        repeat (6) @(posedge clk);
        @(negedge clk);
        rd(2'd3, v); check("R2 start preload held", v, 16'(r));
        check("R2 active after start", active_o, 1'b1);
        exp_cnt = r; exp_irq = 0; base = irq_seen;
        for (int k = 0; k < 10; k++) begin
          toggle();
          if (qualifies(sel, evt_pin)) begin
            if (exp_cnt == 0) begin exp_cnt = r; exp_irq++; end
            else exp_cnt--;
          end
          rd(2'd3, v); check("R3 count after edge", v, 16'(exp_cnt));
        end
        check("R4 interrupt count", irq_seen - base, exp_irq);
      end
    end

    // R10 latency: count changes on third clock edge after pin change
    wr(2'd0, 16'h0002);
    wr(2'd2, 16'h0002);
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h0001);
    repeat (4) @(posedge clk);
    @(negedge clk);
    evt_pin = ~evt_pin;
    @(posedge clk); @(posedge clk); #1;
    rd(2'd3, v); check("R10 no change after two edges", v, 16'd9);
    @(posedge clk); #1;
    rd(2'd3, v); check("R10 change at third edge", v, 16'd8);
    @(negedge clk);

    // R7 trigger register reads zero
    rd(2'd0, v); check("R7 trigger reads zero", v, 16'h0000);

    // R9 mode locked while active, status bit 8
    rd(2'd2, v); check("R9 status active", v, 16'h0102);
    wr(2'd2, 16'h0005);
    rd(2'd2, v); check("R9 mode write ignored while active", v, 16'h0102);

    // R5 stop holds
    toggle(); toggle();
    rd(2'd3, v); check("R3 both edges count", v, 16'd6);
    wr(2'd0, 16'h0002);
    check("R5 inactive after stop", active_o, 1'b0);
    base = irq_seen;
    toggle(); toggle(); toggle();
    rd(2'd3, v); check("R5 counter holds after stop", v, 16'd6);
    check("R5 no irq while stopped", irq_seen - base, 0);

    // R9 mode writable while idle, including out-enable bit
    wr(2'd2, 16'h0005);
    rd(2'd2, v); check("R9 mode write accepted idle", v, 16'h0005);
    wr(2'd2, 16'h0002);

    // R6 stop wins over start
    wr(2'd0, 16'h0001);
    check("R6 running before combined write", active_o, 1'b1);
    wr(2'd0, 16'h0003);
    check("R6 stop wins", active_o, 1'b0);
    rd(2'd0, v); check("R7 trigger reads zero after write", v, 16'h0000);
    wr(2'd0, 16'h0003);
    check("R6 combined write from idle stays idle", active_o, 1'b0);

    // R8 reload rewritten while counting
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0001);
    toggle();
    rd(2'd3, v); check("R8 count before rewrite", v, 16'd2);
    wr(2'd1, 16'd1);
    rd(2'd3, v); check("R8 counter untouched by reload write", v, 16'd2);
    base = irq_seen;
    toggle(); toggle();
    rd(2'd3, v); check("R8 reached zero", v, 16'd0);
    toggle();
    rd(2'd3, v); check("R8 refill uses new value", v, 16'd1);
    check("R4 irq on refill", irq_seen - base, 1);
    toggle(); toggle();
    rd(2'd3, v); check("R8 second refill", v, 16'd1);
    check("R4 irq second refill", irq_seen - base, 2);

    // R1 unit disable: defaults and blocked writes
    wr(2'd2, 16'h0001);
    @(negedge clk);
    unit_en = 1'b0;
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0001);
    rd(2'd3, v); check("R1 unit off counter", v, 16'hFFFF);
    rd(2'd1, v); check("R1 unit off reload", v, 16'h0000);
    rd(2'd2, v); check("R1 unit off mode", v, 16'h0000);
    check("R1 unit off inactive", active_o, 1'b0);
    @(negedge clk);
    unit_en = 1'b1;
    @(negedge clk);
    rd(2'd1, v); check("R1 write blocked while off", v, 16'h0000);
    check("R1 start blocked while off", active_o, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule